// File: doc/BRIEF.md
# B-channel HDLC host FIFO controller

This block is the host-side half of one B-channel HDLC controller. The host programs a mode byte, a command byte and a transmit length through a control write. It then fills a transmit FIFO through a byte write port and drains a receive FIFO through a byte read port. A separate serial framing engine does bit stuffing, flag insertion and CRC work. That engine sees only a byte-wide transmit stream with a last-byte marker, a byte-wide receive stream with an end-of-frame marker, and a CRC-ok flag that is qualified by the frame end.

A 16-bit status word returns three sticky interrupt flags: transmit pool ready, transmit underrun and receive pool ready. It also returns receive overflow, a three-bit frame-validity field, an end-of-message flag and the number of bytes waiting in the receive FIFO. A status read strobe clears the interrupt flags. Transmit reset and receive reset are level commands. Each FIFO stays flushed while its command bit is 1 and is released when the host writes the bit back to 0.

Top module: `hfc_bchan_ctl`

## Requirements
- R1: After reset, `stat` is 0, `irq` is 0, `tx_valid` is 0 and `cfg_mode` is 0.
- R2: The interrupt flags are `stat[7]` (transmit ready), `stat[6]` (transmit underrun) and `stat[5]` (receive ready). Each stays set until a cycle with `stat_rd` high clears it. `irq` is high whenever any of the three is set.
- R3: A control write with `ctl_len` = 0 announces a full FIFO load of DEPTH bytes (32 by default). All DEPTH bytes are accepted, and only the last one carries `tx_last` when `ctl_cmd[0]` (message end) was 1.
- R4: A control write with `ctl_len` = L (1..DEPTH-1) accepts exactly L host bytes. Extra host bytes are dropped. The bytes leave on the stream in write order, and the L-th byte carries `tx_last` when `ctl_cmd[0]` was 1.
- R5: When `ctl_mode[1]` (transparent) is set in the control write, the message-end bit is ignored and no byte carries `tx_last`.
- R6: Transmit ready sets only after a load has completed and the transmit FIFO has drained. It is not set while announced bytes are still in the FIFO.
- R7: In non-transparent mode, when the engine is ready and the transmit FIFO is empty in the middle of a frame (the last byte sent had no `tx_last`), transmit underrun sets once and the frame is abandoned. Transparent mode never sets it.
- R8: While `ctl_cmd[7]` (transmit reset) is held at 1, the transmit FIFO is empty within one clock, `tx_valid` is 0 and host bytes are dropped. Writing the bit back to 0 releases the path, and the release write's length takes effect.
- R9: A received byte with `rx_last` in non-transparent mode sets `stat[0]` and sets receive ready. It also loads `stat[3:1]` with 3'b011 when `rx_crc_ok` is 1 and with 3'b001 otherwise. `stat[13:8]` holds the receive FIFO byte count. `stat[0]` and `stat[3:1]` clear once the host has read the FIFO empty.
- R10: A received byte that arrives while the receive FIFO is full, or while a finished frame is still unread, is dropped. It sets `stat[4]` (overflow), which stays set and blocks further receive bytes until receive reset.
- R11: While `ctl_cmd[5]` (receive reset) is held at 1, the receive FIFO, `stat[4]`, `stat[3:1]` and `stat[0]` clear within one clock and incoming bytes are dropped. After release, reception works again.
- R12: Receive ready also sets when the receive FIFO fills to DEPTH/2 bytes. In transparent mode, `rx_last` neither sets `stat[0]` nor raises receive ready.
- R13: `cfg_mode` presents the last written mode byte to the serial engine: bit 0 flag fill, bit 1 transparent, bits 2 and 3 CRC length, bit 7 loopback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_mode | input | 8 | Mode byte |
| ctl_cmd | input | 8 | Command byte: bit 7 transmit reset, bit 5 receive reset, bit 0 message end |
| ctl_len | input | 6 | Transmit load length, 0 means DEPTH |
| txd_we | input | 1 | Transmit FIFO byte write strobe |
| txd | input | 8 | Transmit FIFO byte |
| rxd_re | input | 1 | Receive FIFO byte read strobe |
| rxd | output | 8 | Receive FIFO head byte |
| stat_rd | input | 1 | Status read strobe, clears interrupt flags |
| stat | output | 16 | Status word |
| irq | output | 1 | Any interrupt flag pending |
| cfg_mode | output | 8 | Mode byte to the serial engine |
| tx_valid | output | 1 | Transmit stream byte valid |
| tx_data | output | 8 | Transmit stream byte |
| tx_last | output | 1 | Transmit stream frame end |
| tx_ready | input | 1 | Serial engine takes a transmit byte |
| rx_valid | input | 1 | Receive stream byte valid |
| rx_data | input | 8 | Receive stream byte |
| rx_last | input | 1 | Receive stream frame end |
| rx_crc_ok | input | 1 | CRC good, qualified by `rx_last` |

## Verification
A corrupted length counter shows on the transmit stream within one load. Either an extra or missing byte appears on the stream, or `tx_last` lands on the wrong byte, and transmit ready either never rises or rises one drain early. A stuck in-frame flag produces a spurious underrun bit in the first idle cycle with the engine ready. Receive pointer or frame-end errors show in the status count and in the read-back byte order as soon as the host drains the FIFO. A sticky overflow that failed to clear would stay visible in `stat[4]` one cycle after receive reset.

// File: rtl/hfc_pkg.sv
`timescale 1ns/1ps
package hfc_pkg;
  localparam int unsigned LEN_W = 6;

  // status bit positions
  localparam int unsigned ST_RME = 0;
  localparam int unsigned ST_RDO = 4;
  localparam int unsigned ST_RPR = 5;
  localparam int unsigned ST_XDU = 6;
  localparam int unsigned ST_XPR = 7;

  // command and mode bit positions
  localparam int unsigned CMD_XME  = 0;
  localparam int unsigned CMD_RRS  = 5;
  localparam int unsigned CMD_XRS  = 7;
  localparam int unsigned MODE_TRN = 1;

  // length code 0 stands for a whole FIFO
  function automatic logic [LEN_W-1:0] len_to_count(input logic [LEN_W-1:0] len,
                                                    input logic [LEN_W-1:0] full_code);
    return (len == '0) ? full_code : len;
  endfunction

  // frame validity field: {abort, crc good, frame valid}
  function automatic logic [2:0] crc_field(input logic ok);
    return {1'b0, ok, 1'b1};
  endfunction

  function automatic logic [15:0] pack_status(input logic [LEN_W-1:0] rml,
                                              input logic xpr, input logic xdu,
                                              input logic rpr, input logic rdo,
                                              input logic [2:0] crc, input logic rme);
    return {2'b00, rml, xpr, xdu, rpr, rdo, crc, rme};
  endfunction
endpackage

// File: rtl/hfc_fifo.sv
`timescale 1ns/1ps
module hfc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       rd,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign full  = (cnt == CW'(DEPTH));
  assign do_wr = wr & ~full & ~clr;
  assign do_rd = rd & (cnt != '0) & ~clr;
  assign rdata = mem[rp];
  assign level = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      cnt <= cnt + CW'(do_wr) - CW'(do_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end
endmodule

// File: rtl/hfc_tx.sv
`timescale 1ns/1ps
module hfc_tx
  import hfc_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             transp,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             load_xme,
  input  logic             push,
  input  logic [7:0]       push_data,
  input  logic             tx_ready,
  input  logic             stat_rd,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic             xpr,
  output logic             xdu
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [LEN_W-1:0] need_q;
  logic             xme_q, armed_q, inframe_q;
  logic [8:0]       head;
  logic [CW-1:0]    level;
  logic             full, empty, push_ok, pop, last_in, xpr_ev, xdu_ev;

  assign empty   = (level == '0);
  assign push_ok = push & ~clr & (need_q != '0) & ~full;
  assign last_in = xme_q & (need_q == LEN_W'(1));
  assign tx_valid = ~empty & ~clr;
  assign pop     = tx_valid & tx_ready;
  assign tx_data = head[7:0];
  assign tx_last = head[8];
  // R6: ready only after a completed load has drained
  assign xpr_ev  = armed_q & empty & ~clr;
  // R7: engine starved inside a frame
  assign xdu_ev  = inframe_q & tx_ready & empty & ~transp & ~clr;

  hfc_fifo #(.W(9), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .wr    (push_ok),
    .wdata ({last_in, push_data}),
    .rd    (pop),
    .rdata (head),
    .level (level),
    .full  (full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_q    <= '0;
      xme_q     <= 1'b0;
      armed_q   <= 1'b0;
      inframe_q <= 1'b0;
    end else begin
      if (load) begin
        need_q <= len_to_count(load_len, LEN_W'(DEPTH));
        xme_q  <= load_xme;
      end else if (clr) begin
        need_q <= '0;
        xme_q  <= 1'b0;
      end else if (push_ok) begin
        need_q <= need_q - 1'b1;
      end
      if (clr)                                  armed_q <= 1'b0;
      else if (push_ok && need_q == LEN_W'(1))  armed_q <= 1'b1;
      else if (xpr_ev)                          armed_q <= 1'b0;
      if (clr)         inframe_q <= 1'b0;
      else if (pop)    inframe_q <= ~head[8];
      else if (xdu_ev) inframe_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xpr <= 1'b0;
      xdu <= 1'b0;
    end else begin
      xpr <= xpr_ev | (xpr & ~stat_rd);
      xdu <= xdu_ev | (xdu & ~stat_rd);
    end
  end
endmodule

// File: rtl/hfc_rx.sv
`timescale 1ns/1ps
module hfc_rx
  import hfc_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   transp,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  input  logic                   rx_last,
  input  logic                   rx_crc_ok,
  input  logic                   pop_req,
  input  logic                   stat_rd,
  output logic [7:0]             rd_data,
  output logic [$clog2(DEPTH):0] level,
  output logic                   rme,
  output logic                   rdo,
  output logic [2:0]             crc,
  output logic                   rpr
);
  localparam int CW  = $clog2(DEPTH) + 1;
  localparam int THR = DEPTH / 2;

  logic full, empty, arrive, accept, ovf_ev, end_ev, thr_ev, pop;

  assign empty  = (level == '0);
  assign arrive = rx_valid & ~clr;
  assign accept = arrive & ~full & ~rme & ~rdo;
  assign ovf_ev = arrive & (full | rme);            // R10
  assign end_ev = accept & rx_last & ~transp;       // R9, R12
  assign thr_ev = accept & (level == CW'(THR - 1)); // R12
  assign pop    = pop_req & ~empty & ~clr;

  hfc_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .wr    (accept),
    .wdata (rx_data),
    .rd    (pop),
    .rdata (rd_data),
    .level (level),
    .full  (full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rme <= 1'b0;
      rdo <= 1'b0;
      crc <= '0;
    end else if (clr) begin
      rme <= 1'b0;
      rdo <= 1'b0;
      crc <= '0;
    end else begin
      if (end_ev) begin
        rme <= 1'b1;
        crc <= crc_field(rx_crc_ok);
      end else if (rme && empty) begin
        rme <= 1'b0;
        crc <= '0;
      end
      rdo <= rdo | ovf_ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rpr <= 1'b0;
    else        rpr <= end_ev | thr_ev | (rpr & ~stat_rd);
  end
endmodule

// File: rtl/hfc_bchan_ctl.sv
`timescale 1ns/1ps
module hfc_bchan_ctl
  import hfc_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_mode,
  input  logic [7:0]       ctl_cmd,
  input  logic [LEN_W-1:0] ctl_len,
  input  logic             txd_we,
  input  logic [7:0]       txd,
  input  logic             rxd_re,
  output logic [7:0]       rxd,
  input  logic             stat_rd,
  output logic [15:0]      stat,
  output logic             irq,
  output logic [7:0]       cfg_mode,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic             rx_crc_ok
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [7:0]    mode_q;
  logic          tx_clr, rx_clr;
  logic          tx_load, tx_xme, transp;
  logic          xpr, xdu, rpr, rme, rdo;
  logic [2:0]    crc;
  logic [CW-1:0] rx_level;

  // level commands: held until the host writes them back to 0 (R8, R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      tx_clr <= 1'b0;
      rx_clr <= 1'b0;
    end else if (ctl_we) begin
      mode_q <= ctl_mode;
      tx_clr <= ctl_cmd[CMD_XRS];
      rx_clr <= ctl_cmd[CMD_RRS];
    end
  end

  assign transp   = mode_q[MODE_TRN];
  assign cfg_mode = mode_q;
  assign tx_load  = ctl_we & ~ctl_cmd[CMD_XRS];
  assign tx_xme   = ctl_cmd[CMD_XME] & ~ctl_mode[MODE_TRN]; // R5

  hfc_tx #(.DEPTH(DEPTH)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (tx_clr),
    .transp    (transp),
    .load      (tx_load),
    .load_len  (ctl_len),
    .load_xme  (tx_xme),
    .push      (txd_we),
    .push_data (txd),
    .tx_ready  (tx_ready),
    .stat_rd   (stat_rd),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .xpr       (xpr),
    .xdu       (xdu)
  );

  hfc_rx #(.DEPTH(DEPTH)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rx_clr),
    .transp    (transp),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_last   (rx_last),
    .rx_crc_ok (rx_crc_ok),
    .pop_req   (rxd_re),
    .stat_rd   (stat_rd),
    .rd_data   (rxd),
    .level     (rx_level),
    .rme       (rme),
    .rdo       (rdo),
    .crc       (crc),
    .rpr       (rpr)
  );

  assign stat = pack_status(LEN_W'(rx_level), xpr, xdu, rpr, rdo, crc, rme);
  assign irq  = xpr | xdu | rpr;
endmodule

// File: rtl/hfc_bchan_ctl_chk.sv
`timescale 1ns/1ps
module hfc_bchan_ctl_chk #(
  parameter int DEPTH = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] stat,
  input logic        stat_rd,
  input logic        tx_valid,
  input logic [7:0]  cfg_mode,
  input logic        tx_clr,
  input logic        rx_clr
);
  p_rml_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat[13:8] <= 6'(DEPTH));

  p_sticky_xpr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat[7] && !stat_rd |=> stat[7]);

  p_xpr_after_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[7]) |-> $past(!tx_valid));

  p_xdu_nontransp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[6]) |-> !$past(cfg_mode[1]));

  p_tx_release_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_clr) |-> !tx_valid);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat[4] && !rx_clr |=> stat[4]);

  p_rx_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (stat[13:8] == 6'd0) && !stat[4] && !stat[0]);
endmodule

bind hfc_bchan_ctl hfc_bchan_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stat     (stat),
  .stat_rd  (stat_rd),
  .tx_valid (tx_valid),
  .cfg_mode (cfg_mode),
  .tx_clr   (tx_clr),
  .rx_clr   (rx_clr)
);

// File: tb/hfc_bchan_ctl_tb.sv
`timescale 1ns/1ps
module hfc_bchan_ctl_tb;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 0, txd_we = 0, rxd_re = 0, stat_rd = 0, tx_ready = 0;
  logic [7:0] ctl_mode = 0, ctl_cmd = 0, txd = 0;
  logic [5:0] ctl_len = 0;
  logic       rx_valid = 0, rx_last = 0, rx_crc_ok = 0;
  logic [7:0] rx_data = 0;
  logic [7:0] rxd, cfg_mode, tx_data;
  logic [15:0] stat;
  logic       irq, tx_valid, tx_last;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [8:0] txq[$];
  logic [7:0] rxq[$];

  always #2.5 clk = ~clk;

  hfc_bchan_ctl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_mode(ctl_mode), .ctl_cmd(ctl_cmd),
    .ctl_len(ctl_len), .txd_we(txd_we), .txd(txd), .rxd_re(rxd_re), .rxd(rxd),
    .stat_rd(stat_rd), .stat(stat), .irq(irq), .cfg_mode(cfg_mode),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_crc_ok(rx_crc_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic ctl_write(input logic [7:0] m, input logic [7:0] c, input logic [5:0] l);
    ctl_we = 1; ctl_mode = m; ctl_cmd = c; ctl_len = l;
    tick();
    ctl_we = 0;
  endtask

  // driver: pushes the expected stream item when the byte should be accepted
  task automatic push_tx(input logic [7:0] d, input bit expect_it, input bit last);
    if (expect_it) txq.push_back({last, d});
    txd_we = 1; txd = d;
    tick();
    txd_we = 0;
  endtask

  task automatic rx_send(input logic [7:0] d, input bit last, input bit ok, input bit expect_it);
    if (expect_it) rxq.push_back(d);
    rx_valid = 1; rx_data = d; rx_last = last; rx_crc_ok = ok;
    tick();
    rx_valid = 0; rx_last = 0; rx_crc_ok = 0;
  endtask

  task automatic rd_rx(input string req);
    logic [7:0] e;
    e = (rxq.size() != 0) ? rxq.pop_front() : 8'hxx;
    chk(req, rxd, e);
    rxd_re = 1;
    tick();
    rxd_re = 0;
  endtask

  task automatic stat_clear();
    stat_rd = 1;
    tick();
    stat_rd = 0;
  endtask

  // monitor: transmit stream scoreboard (R3 R4 R5 R7)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx_valid && tx_ready) begin
        if (txq.size() == 0) begin
          chk("R4 unexpected tx byte", {23'd0, tx_last, tx_data}, 32'h1ff);
        end else begin
          logic [8:0] e;
          e = txq.pop_front();
          chk("R4 tx stream byte", {23'd0, tx_last, tx_data}, {23'd0, e});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    // R1
    chk("R1 stat", stat, 16'h0000);
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 cfg_mode", cfg_mode, 0);

    // R13
    ctl_write(8'h09, 8'h00, 6'd1);
    chk("R13 cfg_mode", cfg_mode, 8'h09);

    // R4 partial load of 5 with message end, extra byte dropped
    ctl_write(8'h01, 8'h01, 6'd5);
    for (int i = 0; i < 5; i++) push_tx(8'hA0 + 8'(i), 1, i == 4);
    push_tx(8'hAF, 0, 0);
    chk("R6 no ready before drain", stat, 16'h0000);
    tx_ready = 1;
    tick(12);
    chk("R6 ready after drain", stat, 16'h0080);
    chk("R2 irq pending", irq, 1);
    stat_clear();
    chk("R2 cleared by read", stat, 16'h0000);
    chk("R4 queue drained", txq.size(), 0);
    tx_ready = 0;

    // R3 full load, length code 0
    ctl_write(8'h00, 8'h01, 6'd0);
    for (int i = 0; i < DEPTH; i++) push_tx(8'h40 + 8'(i), 1, i == DEPTH - 1);
    chk("R3 no ready before drain", stat, 16'h0000);
    tx_ready = 1;
    tick(DEPTH + 8);
    chk("R3 ready after full drain", stat, 16'h0080);
    chk("R3 queue drained", txq.size(), 0);
    stat_clear();
    tx_ready = 0;

    // R5 transparent: message end ignored, no underrun
    ctl_write(8'h02, 8'h01, 6'd3);
    for (int i = 0; i < 3; i++) push_tx(8'h70 + 8'(i), 1, 0);
    tx_ready = 1;
    tick(10);
    chk("R5 ready only, no underrun", stat, 16'h0080);
    stat_clear();
    tx_ready = 0;

    // R8 transmit reset
    ctl_write(8'h00, 8'h01, 6'd3);
    push_tx(8'hE0, 0, 0);
    push_tx(8'hE1, 0, 0);
    chk("R8 data pending before reset", tx_valid, 1);
    ctl_write(8'h00, 8'h80, 6'd0);
    tick();
    chk("R8 flushed", tx_valid, 0);
    push_tx(8'hE2, 0, 0);
    chk("R8 push ignored in reset", tx_valid, 0);
    ctl_write(8'h00, 8'h00, 6'd2);
    chk("R8 empty after release", tx_valid, 0);

    // R7 underrun in mid-frame
    push_tx(8'hC0, 1, 0);
    push_tx(8'hC1, 1, 0);
    chk("R7 no flags yet", stat, 16'h0000);
    tx_ready = 1;
    tick(8);
    chk("R7 underrun and ready", stat, 16'h00C0);
    stat_clear();
    chk("R7 underrun once", stat, 16'h0000);
    tx_ready = 0;

    // R9 good frame
    for (int i = 0; i < 4; i++) rx_send(8'hD0 + 8'(i), i == 3, 1, 1);
    chk("R9 good frame status", stat, 16'h0427);
    chk("R9 irq", irq, 1);
    for (int i = 0; i < 4; i++) rd_rx("R9 rx data");
    tick();
    chk("R9 end cleared after read", stat, 16'h0020);
    stat_clear();
    chk("R9 clear", stat, 16'h0000);

    // R9 bad crc
    rx_send(8'h5A, 0, 0, 1);
    rx_send(8'h5B, 1, 0, 1);
    chk("R9 bad crc status", stat, 16'h0223);
    rd_rx("R9 rx data bad");
    rd_rx("R9 rx data bad");
    tick();
    stat_clear();
    chk("R9 clear bad", stat, 16'h0000);

    // R10 overflow while a finished frame is unread
    rx_send(8'h11, 1, 1, 1);
    chk("R10 one byte frame", stat, 16'h0127);
    rx_send(8'h22, 0, 0, 0);
    chk("R10 overflow set", stat, 16'h0137);
    rd_rx("R10 dropped byte absent");
    tick();
    chk("R10 overflow sticky", stat, 16'h0030);

    // R11 receive reset
    ctl_write(8'h00, 8'h20, 6'd1);
    tick();
    chk("R11 cleared", stat, 16'h0020);
    rx_send(8'h33, 0, 0, 0);
    chk("R11 byte ignored", stat, 16'h0020);
    ctl_write(8'h00, 8'h00, 6'd1);
    stat_clear();
    chk("R11 all clear", stat, 16'h0000);
    rx_send(8'h44, 1, 1, 1);
    chk("R11 receive after release", stat, 16'h0127);
    rd_rx("R11 rx data");
    tick();
    stat_clear();
    chk("R11 idle", stat, 16'h0000);

    // R12 threshold, R10 full overflow
    for (int i = 0; i < DEPTH/2 - 1; i++) rx_send(8'h80 + 8'(i), 0, 0, 1);
    chk("R12 below threshold", stat, 16'h0F00);
    rx_send(8'h8F, 0, 0, 1);
    chk("R12 threshold ready", stat, 16'h1020);
    for (int i = DEPTH/2; i < DEPTH; i++) rx_send(8'h80 + 8'(i), 0, 0, 1);
    chk("R10 full", stat, 16'h2020);
    rx_send(8'hFF, 0, 0, 0);
    chk("R10 full overflow", stat, 16'h2030);
    for (int i = 0; i < DEPTH; i++) rd_rx("R10 rx order");
    tick();
    chk("R10 drained, overflow kept", stat, 16'h0030);
    ctl_write(8'h00, 8'h20, 6'd1);
    tick();
    ctl_write(8'h00, 8'h00, 6'd1);
    stat_clear();
    chk("R11 reset after full", stat, 16'h0000);

    // R12 transparent receive
    ctl_write(8'h02, 8'h00, 6'd1);
    rx_send(8'h91, 0, 0, 1);
    rx_send(8'h92, 0, 0, 1);
    rx_send(8'h93, 1, 1, 1);
    chk("R12 transparent no end", stat, 16'h0300);
    for (int i = 0; i < 3; i++) rd_rx("R12 transparent data");
    tick();
    chk("R12 transparent drained", stat, 16'h0000);

    chk("R4 tx queue empty", txq.size(), 0);
    chk("R9 rx queue empty", rxq.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule